// File: doc/BRIEF.md
# Sampling Converter Serial Readout Port

This block is the read-only output stage of a 24-bit sampling converter. A frame-tick strobe from the upstream conversion logic presents a new 32-bit signed result. The block saturates that result to a 24-bit two's complement word and loads it into an output shift register. It then signals through an active-low ready flag that the word can be read. An external reader returns the serial clock low between reads and collects the word MSB first, taking one bit per falling serial-clock edge.

Several devices can share one readout line. The serial output of one device is wired to the chain input of the next. Bits taken in on the chain input follow the local word out of the data pin. When a word is never read, the ready flag still marks each new result: it goes high for one master-clock cycle and then low again. The serial clock and the chain input are asynchronous to the master clock, so both pass through a synchronizer. The falling edge of the serial clock is detected in the master-clock domain.

Top module: `conv_readout_port`

## Requirements
- R1: A sample in the range -8388608 to +8388607 is loaded as its low 24 bits, which are its two's complement code.
- R2: A sample above +8388607 is loaded as 7FFFFFh.
- R3: A sample below -8388608 is loaded as 800000h.
- R4: The word is loaded at the master-clock edge that samples frame_tick high. In the cycle after that edge ready_n is high, and at the next edge it goes low. The load therefore comes exactly one master-clock cycle before ready_n falls.
- R5: When ready_n goes low, dout already carries bit 23 of the word. Each falling sclk edge then presents the next lower bit, so the word leaves MSB first.
- R6: The first falling sclk edge after ready_n went low returns ready_n high. It stays high until the next frame tick.
- R7: If a word is left unread or only partly read when the next frame tick arrives, ready_n is high for exactly one master-clock cycle. The new word replaces the old one, and the old word's remaining bits are lost.
- R8: A din value is captured on each falling sclk edge. The value captured on the k-th falling edge after a load appears on dout at bit position 24+k of the stream, counting from 0.
- R9: With din held low, every bit read after the 24 local bits is 0.
- R10: While rst_n is low, ready_n is high and dout is low. rst_n is asserted asynchronously and its release takes effect synchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously |
| frame_tick | input | 1 | One-cycle strobe marking a new sample |
| raw_sample | input | 32 | Signed raw result, saturated to 24 bits when loaded |
| sclk | input | 1 | Serial clock from the reader; must run no faster than half of clk |
| din | input | 1 | Chain input from the preceding device; tie low when unused |
| ready_n | output | 1 | Active-low data-ready flag |
| dout | output | 1 | Serial data, MSB first |

## Verification
On every cycle the assertions check the ready sequence around a frame tick. That sequence is high in the cycle after the tick and falls only two cycles after a tick with no tick in between. They also check that a detected falling serial edge releases ready_n, that dout changes only on a load or a shift, and that the first bit after a load carries the sign of the raw sample. Only the bench scenarios can show the full content of the serial stream. That covers the clipped codes, the order of the chain bits after the local word, the zero fill, and the loss of a half-read word when a new one lands.

// File: rtl/crp_pkg.sv
package crp_pkg;

  // Ready-flag sequencer states
  typedef enum logic [1:0] {
    RDY_IDLE = 2'd0,  // nothing pending, flag high
    RDY_ARM  = 2'd1,  // word just loaded, flag high for one cycle
    RDY_LOW  = 2'd2   // word waiting to be read, flag low
  } rdy_state_t;

endpackage

// File: rtl/crp_rst_sync.sv
module crp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/crp_sync_edge.sv
module crp_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_in,
  input  logic chain_in,
  output logic sclk_fall,
  output logic chain_bit
);

  logic [STAGES-1:0] sclk_q;
  logic [STAGES-1:0] chain_q;
  logic              sclk_last_q;

  // Both inputs see the same depth, so the captured chain bit stays aligned
  // with the clock edge detected alongside it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q      <= '0;
      chain_q     <= '0;
      sclk_last_q <= 1'b0;
    end else begin
      sclk_q      <= {sclk_q[STAGES-2:0], sclk_in};
      chain_q     <= {chain_q[STAGES-2:0], chain_in};
      sclk_last_q <= sclk_q[STAGES-1];
    end
  end

  assign sclk_fall = sclk_last_q & ~sclk_q[STAGES-1];
  assign chain_bit = chain_q[STAGES-1];

endmodule

// File: rtl/crp_saturate.sv
module crp_saturate #(
  parameter int unsigned IN_W  = 32,
  parameter int unsigned OUT_W = 24
) (
  input  logic [IN_W-1:0]  raw,
  output logic [OUT_W-1:0] word
);

  localparam int unsigned TOP_W = IN_W - OUT_W + 1;

  logic [TOP_W-1:0] top_bits;
  logic             all_ones;
  logic             all_zeros;

  assign top_bits  = raw[IN_W-1:OUT_W-1];
  assign all_ones  = &top_bits;
  assign all_zeros = ~|top_bits;

  always_comb begin
    if (all_ones || all_zeros) begin
      word = raw[OUT_W-1:0];
    end else if (raw[IN_W-1]) begin
      word = {1'b1, {(OUT_W-1){1'b0}}};
    end else begin
      word = {1'b0, {(OUT_W-1){1'b1}}};
    end
  end

endmodule

// File: rtl/crp_shifter.sv
module crp_shifter #(
  parameter int unsigned W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [W-1:0] load_word,
  input  logic         shift_en,
  input  logic         ser_in,
  output logic         ser_out
);

  logic [W-1:0] sh_q;
  logic [W-1:0] sh_d;
  logic         sh_en;

  // A load wins over a shift in the same cycle.
  always_comb begin
    sh_en = load_en | shift_en;
    if (load_en) begin
      sh_d = load_word;
    end else begin
      sh_d = {sh_q[W-2:0], ser_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else if (sh_en) begin
      sh_q <= sh_d;
    end
  end

  assign ser_out = sh_q[W-1];

endmodule

// File: rtl/crp_ready_ctrl.sv
module crp_ready_ctrl
  import crp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic fall,
  output logic ready_n
);

  rdy_state_t state_q;
  rdy_state_t state_d;
  logic       ready_n_q;
  logic       ready_n_d;

  always_comb begin
    state_d = state_q;
    if (tick) begin
      state_d = RDY_ARM;
    end else begin
      unique case (state_q)
        RDY_ARM:  state_d = fall ? RDY_IDLE : RDY_LOW;
        RDY_LOW:  state_d = fall ? RDY_IDLE : RDY_LOW;
        default:  state_d = RDY_IDLE;
      endcase
    end
    ready_n_d = (state_d != RDY_LOW);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= RDY_IDLE;
      ready_n_q <= 1'b1;
    end else begin
      state_q   <= state_d;
      ready_n_q <= ready_n_d;
    end
  end

  assign ready_n = ready_n_q;

endmodule

// File: rtl/conv_readout_port.sv
module conv_readout_port #(
  parameter int unsigned RAW_W       = 32,
  parameter int unsigned WORD_W      = 24,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_tick,
  input  logic [RAW_W-1:0] raw_sample,
  input  logic             sclk,
  input  logic             din,
  output logic             ready_n,
  output logic             dout
);

  logic              rst_sync_n;
  logic              sclk_fall;
  logic              chain_bit;
  logic [WORD_W-1:0] sat_word;
  logic              raw_sign;

  assign raw_sign = raw_sample[RAW_W-1];

  crp_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  crp_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .sclk_in   (sclk),
    .chain_in  (din),
    .sclk_fall (sclk_fall),
    .chain_bit (chain_bit)
  );

  crp_saturate #(.IN_W(RAW_W), .OUT_W(WORD_W)) u_sat (
    .raw  (raw_sample),
    .word (sat_word)
  );

  crp_shifter #(.W(WORD_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load_en   (frame_tick),
    .load_word (sat_word),
    .shift_en  (sclk_fall),
    .ser_in    (chain_bit),
    .ser_out   (dout)
  );

  crp_ready_ctrl u_rdy (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .tick    (frame_tick),
    .fall    (sclk_fall),
    .ready_n (ready_n)
  );

endmodule

// File: rtl/crp_checker.sv
module crp_checker (
  input logic clk,
  input logic rst_n,
  input logic frame_tick,
  input logic raw_sign,
  input logic sclk_fall,
  input logic ready_n,
  input logic dout
);

  // R4: the cycle after a load edge shows the flag high
  p_tick_raises_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_tick |=> ready_n)
    else $error("R4: ready_n not high after tick");

  // R4 / R7: the flag only falls two cycles after a tick, with none in between
  p_ready_fall_timing_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready_n) |-> ($past(frame_tick, 2) && !$past(frame_tick)))
    else $error("R7: ready_n fell without matching tick");

  // R1 / R2 / R3: the first bit after a load is the sign of the raw sample
  p_load_sign_r1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_tick |=> (dout == $past(raw_sign)))
    else $error("R1: loaded MSB differs from sample sign");

  // R6: a detected falling edge without a tick leaves the flag high
  p_fall_releases_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_fall && !frame_tick) |=> ready_n)
    else $error("R6: ready_n low after serial fall");

  // R5: without a load or a shift the data pin holds
  p_dout_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_tick && !sclk_fall) |=> $stable(dout))
    else $error("R5: dout moved without load or shift");

endmodule

bind conv_readout_port crp_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .frame_tick (frame_tick),
  .raw_sign   (raw_sign),
  .sclk_fall  (sclk_fall),
  .ready_n    (ready_n),
  .dout       (dout)
);

// File: tb/conv_readout_port_test.sv
module conv_readout_port_test;

  logic        clk;
  logic        rst_n;
  logic        frame_tick;
  logic [31:0] raw_sample;
  logic        sclk;
  logic        din;
  logic        ready_n;
  logic        dout;

  int n_checks;
  int n_fails;
  bit done;

  conv_readout_port uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_tick (frame_tick),
    .raw_sample (raw_sample),
    .sclk       (sclk),
    .din        (din),
    .ready_n    (ready_n),
    .dout       (dout)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [23:0] sat24(input logic signed [31:0] v);
    if (v > 32'sd8388607) return 24'h7FFFFF;
    if (v < -32'sd8388608) return 24'h800000;
    return v[23:0];
  endfunction

  // Present one sample; checks the one-cycle high and the fall to low.
  task automatic pulse_tick(input logic [31:0] v, input string req);
    logic [23:0] w;
    w = sat24(v);
    @(negedge clk);
    raw_sample = v;
    frame_tick = 1'b1;
    @(negedge clk);
    frame_tick = 1'b0;
    chk(ready_n == 1'b1, req, "ready_n in load cycle", 32'(ready_n), 32'd1);
    @(negedge clk);
    chk(ready_n == 1'b0, req, "ready_n after load", 32'(ready_n), 32'd0);
    chk(dout == w[23], req, "MSB at ready", 32'(dout), 32'(w[23]));
  endtask

  // Shift nbits out; din gets chain[k] on fall k. Stream compared bit by bit.
  task automatic read_bits(input logic [23:0] w, input int nbits,
                           input logic [39:0] chain, input string req);
    int errs;
    logic exp_b;
    errs = 0;
    for (int k = 0; k < nbits; k++) begin
      @(negedge clk);
      exp_b = (k < 24) ? w[23-k] : chain[k-24];
      if (dout !== exp_b) begin
        errs++;
        $display("FAIL %s bit %0d: actual %0b expected %0b", req, k, dout, exp_b);
      end
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      din  = (k < 40) ? chain[k] : 1'b0;
      sclk = 1'b0;
      repeat (4) @(negedge clk);
      if (k == 0)
        chk(ready_n == 1'b1, "R6", "ready_n after first fall", 32'(ready_n), 32'd1);
    end
    din = 1'b0;
    n_checks++;
    if (errs != 0) n_fails++;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    frame_tick = 1'b0;
    raw_sample = '0;
    sclk = 1'b0;
    din = 1'b0;
    repeat (3) @(negedge clk);
    chk(ready_n == 1'b1, "R10", "ready_n in reset", 32'(ready_n), 32'd1);
    chk(dout == 1'b0, "R10", "dout in reset", 32'(dout), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(ready_n == 1'b1, "R10", "ready_n after release", 32'(ready_n), 32'd1);
  endtask

  task automatic t_in_range();
    pulse_tick(32'h0012_3456, "R4");
    read_bits(24'h123456, 24, '0, "R5");
    pulse_tick(32'hFFFF_FFFB, "R1");
    read_bits(24'hFFFFFB, 24, '0, "R1");
    repeat (10) @(negedge clk);
    chk(ready_n == 1'b1, "R6", "ready_n holds high after read", 32'(ready_n), 32'd1);
  endtask

  task automatic t_clip();
    pulse_tick(32'h0100_0000, "R2");
    read_bits(24'h7FFFFF, 24, '0, "R2");
    pulse_tick(32'hFF70_0000, "R3");
    read_bits(24'h800000, 24, '0, "R3");
    pulse_tick(32'h8000_0000, "R3");
    read_bits(24'h800000, 24, '0, "R3");
  endtask

  task automatic t_chain();
    logic [39:0] pat;
    pat = 40'h00_0000_0000;
    pat[7:0] = 8'b0100_1101;
    pat[31:24] = 8'b1011_0010;
    pulse_tick(32'h0000_0F0F, "R8");
    read_bits(24'h000F0F, 40, pat, "R8");
    pulse_tick(32'hFFFF_FFFF, "R9");
    read_bits(24'hFFFFFF, 32, '0, "R9");
  endtask

  task automatic t_unread();
    pulse_tick(32'h0000_00AA, "R7");
    repeat (6) @(negedge clk);
    chk(ready_n == 1'b0, "R7", "ready_n held low unread", 32'(ready_n), 32'd0);
    pulse_tick(32'hFFF0_0001, "R7");
    read_bits(24'hF00001, 24, '0, "R7");
    pulse_tick(32'h0055_AA33, "R7");
    read_bits(24'h55AA33, 5, '0, "R7");
    pulse_tick(32'h0033_CC55, "R7");
    read_bits(24'h33CC55, 24, '0, "R7");
  endtask

  initial begin
    n_checks = 0;
    n_fails  = 0;
    done     = 1'b0;
    t_reset();
    t_in_range();
    t_clip();
    t_chain();
    t_unread();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

endmodule